// File: doc/BRIEF.md
# PS/2 Host Receive Channel

This block is the host end of a PS/2 link in receive mode. The attached device drives both the clock and the data line. The block brings both lines into its own clock domain through a short synchronizer chain. It detects falling clock edges and assembles 11-bit frames: a low start bit, eight data bits with the least significant bit first, a parity bit and a stop bit. The block only listens while the channel is enabled and set to receive.

A good byte goes into a receive data register and sets a ready flag. Any fault sets a shared timeout flag, and sets a specific parity or framing flag when one applies. The faults are a wrong parity, a wrong stop bit, a clock gap that is too long, and a start-to-parity span that is too long. After any fault the block pulls the clock line low for a fixed hold-off time, so the device stops and later resends.

A single interrupt output pulses when the ready flag or the timeout flag rises. Software clears the ready flag by reading the data register. It clears the error flags by reading the status register. All time limits are given in microseconds and scaled by a clocks-per-microsecond parameter.

Top module: `ps2_rx_channel`

## Requirements
- R1: A frame with correct parity and stop bit puts its eight data bits (first received bit = rx_data[0]) on rx_data. It sets rdy, and irq is high for exactly the one cycle in which rdy turns from 0 to 1.
- R2: rdy stays 1 until a cycle with rd_data high clears it. If a new good byte completes in the same cycle as rd_data, rdy stays 1 and holds the new byte. A second good byte while rdy is 1 overwrites rx_data and gives no new irq.
- R3: The expected parity is odd when par_odd = 1, meaning the data bits plus the parity bit hold an odd number of ones, and even when par_odd = 0. A mismatch at the end of the frame sets pe and tmo. It leaves rdy and rx_data unchanged.
- R4: A stop bit (the 11th bit) that differs from stop_val sets fe and tmo. It leaves rdy and rx_data unchanged.
- R5: While a frame is in progress, if no falling clock edge arrives for BIT_US × CLK_PER_US cycles, tmo is set and the frame is dropped.
- R6: If the parity bit (the 10th bit) has not arrived within FRAME_US × CLK_PER_US cycles of the start bit, tmo is set and the frame is dropped. This happens even when every single bit gap is within the R5 limit.
- R7: After any fault, ps2_clk_oe is high (the clock line is pulled low) for HOLD_US × CLK_PER_US cycles, or one cycle more. Clock edges in that time are ignored. Afterwards the block waits for a new start bit.
- R8: irq pulses for one cycle when tmo turns from 0 to 1. A cycle with rd_status high clears tmo, pe and fe. A fault that lands in the same cycle as rd_status still leaves its flags set.
- R9: busy is 1 from the accepted start bit until the frame completes or fails, and 0 otherwise. After reset every output is 0.
- R10: en = 0 clears rdy, tmo, pe and fe, drops any frame and releases the clock line. rx_mode = 0 drops any frame but keeps the flags. No frame is accepted while either is 0.
- R11: A falling clock edge seen while idle with the data line high is not taken as a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| en | input | 1 | Channel enable; 0 clears the flags and aborts |
| rx_mode | input | 1 | 1 selects receive; 0 aborts a frame |
| par_odd | input | 1 | Expected parity sense: 1 odd, 0 even |
| stop_val | input | 1 | Expected stop bit value |
| rd_data | input | 1 | One-cycle strobe: receive data register read |
| rd_status | input | 1 | One-cycle strobe: status register read |
| ps2_clk_i | input | 1 | Sensed level of the bus clock line |
| ps2_dat_i | input | 1 | Sensed level of the bus data line |
| ps2_clk_oe | output | 1 | 1 pulls the bus clock line low (hold-off) |
| rx_data | output | 8 | Last byte received without error |
| rdy | output | 1 | Received byte waiting to be read |
| pe | output | 1 | Parity error flag |
| fe | output | 1 | Framing (stop bit) error flag |
| tmo | output | 1 | Receive timeout flag, set by every fault |
| busy | output | 1 | Frame reception in progress |
| irq | output | 1 | One-cycle pulse when rdy or tmo rises |

## Verification
A flag can be set and cleared by a register read in the same clock cycle. This happens in two places: a finishing byte against a data read, and a fault against a status read. To provoke each case, the bench holds the matching read strobe high while the frame completes or a bit-gap timeout expires. It drops the strobe on the falling clock edge in which it first sees irq. That edge follows the rising edge where the flag was set while the read was active. The bench then expects the flag to read 1, and the new byte to be on rx_data in the data-read case. This is compared with an ordinary read, which must clear the flag.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_SHIFT = 2'd1,
    RX_HOLD  = 2'd2
  } rx_state_e;

  // Bits counted once the start bit is taken: 1 start + 8 data = 9,
  // then parity, then stop.
  localparam logic [3:0] NBIT_PARITY = 4'd9;
  localparam logic [3:0] NBIT_STOP   = 4'd10;

  // 1 when data plus parity carry the requested sense of ones.
  function automatic logic parity_match(input logic [7:0] d,
                                        input logic       p,
                                        input logic       odd);
    return ((^d) ^ p) == odd;
  endfunction

endpackage

// File: rtl/ps2rx_sync.sv
module ps2rx_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] pipe_q;

  // Idle bus lines are high, so the chain resets to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-2:0], din};
  end

  assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/ps2rx_limit_cnt.sv
module ps2rx_limit_cnt #(
  parameter int unsigned LIMIT = 1200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic hit
);

  localparam int unsigned W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign hit = (cnt_q == W'(LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)             cnt_d = '0;
    else if (run && !hit) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ps2rx_frame.sv
module ps2rx_frame
  import ps2rx_pkg::*;
#(
  parameter int unsigned BIT_LIM   = 1200,
  parameter int unsigned FRAME_LIM = 8000,
  parameter int unsigned HOLD_LIM  = 1200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       clk_fall,
  input  logic       dat_s,
  input  logic       par_odd,
  input  logic       stop_val,
  output logic       done_ok,
  output logic       err_par,
  output logic       err_stop,
  output logic       err_time,
  output logic [7:0] byte_o,
  output logic       busy,
  output logic       hold
);

  rx_state_e  state_q, state_d;
  logic [3:0] nbit_q, nbit_d;
  logic [7:0] shf_q, shf_d;
  logic       pbad_q, pbad_d;
  logic       bit_hit, frame_hit, hold_hit;

  assign busy   = (state_q == RX_SHIFT);
  assign hold   = (state_q == RX_HOLD);
  assign byte_o = shf_q;

  ps2rx_limit_cnt #(.LIMIT(BIT_LIM)) u_bit_cnt (
    .clk(clk), .rst_n(rst_n), .clr(!busy || clk_fall), .run(busy), .hit(bit_hit));

  ps2rx_limit_cnt #(.LIMIT(FRAME_LIM)) u_frame_cnt (
    .clk(clk), .rst_n(rst_n), .clr(!busy), .run(busy), .hit(frame_hit));

  ps2rx_limit_cnt #(.LIMIT(HOLD_LIM)) u_hold_cnt (
    .clk(clk), .rst_n(rst_n), .clr(!hold), .run(hold), .hit(hold_hit));

  always_comb begin
    state_d  = state_q;
    nbit_d   = nbit_q;
    shf_d    = shf_q;
    pbad_d   = pbad_q;
    done_ok  = 1'b0;
    err_par  = 1'b0;
    err_stop = 1'b0;
    err_time = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        if (active && clk_fall && !dat_s) begin
          state_d = RX_SHIFT;
          nbit_d  = 4'd1;
          pbad_d  = 1'b0;
        end
      end
      RX_SHIFT: begin
        if (!active) begin
          state_d = RX_IDLE;
        end else if (clk_fall) begin
          if (nbit_q < NBIT_PARITY) begin
            shf_d  = {dat_s, shf_q[7:1]};
            nbit_d = nbit_q + 4'd1;
          end else if (nbit_q == NBIT_PARITY) begin
            pbad_d = !parity_match(shf_q, dat_s, par_odd);
            nbit_d = NBIT_STOP;
          end else if (pbad_q) begin
            err_par = 1'b1;
            state_d = RX_HOLD;
          end else if (dat_s != stop_val) begin
            err_stop = 1'b1;
            state_d  = RX_HOLD;
          end else begin
            done_ok = 1'b1;
            state_d = RX_IDLE;
          end
        end else if (bit_hit || (frame_hit && nbit_q < NBIT_STOP)) begin
          err_time = 1'b1;
          state_d  = RX_HOLD;
        end
      end
      RX_HOLD: begin
        if (!active || hold_hit) state_d = RX_IDLE;
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      nbit_q  <= '0;
      shf_q   <= '0;
      pbad_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      nbit_q  <= nbit_d;
      shf_q   <= shf_d;
      pbad_q  <= pbad_d;
    end
  end

endmodule

// File: rtl/ps2_rx_channel.sv
module ps2_rx_channel #(
  parameter int unsigned CLK_PER_US = 250,
  parameter int unsigned BIT_US     = 300,
  parameter int unsigned FRAME_US   = 2000,
  parameter int unsigned HOLD_US    = 300,
  parameter int unsigned SYNC_STG   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       rx_mode,
  input  logic       par_odd,
  input  logic       stop_val,
  input  logic       rd_data,
  input  logic       rd_status,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic       ps2_clk_oe,
  output logic [7:0] rx_data,
  output logic       rdy,
  output logic       pe,
  output logic       fe,
  output logic       tmo,
  output logic       busy,
  output logic       irq
);

  localparam int unsigned BIT_LIM   = CLK_PER_US * BIT_US;
  localparam int unsigned FRAME_LIM = CLK_PER_US * FRAME_US;
  localparam int unsigned HOLD_LIM  = CLK_PER_US * HOLD_US;

  logic       clk_s, dat_s, clk_d;
  logic       clk_fall;
  logic       ok, e_par, e_stop, e_time, e_any;
  logic [7:0] frame_byte;

  ps2rx_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({ps2_clk_i, ps2_dat_i}), .dout({clk_s, dat_s}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_d <= 1'b1;
    else        clk_d <= clk_s;
  end

  assign clk_fall = clk_d & ~clk_s;

  ps2rx_frame #(.BIT_LIM(BIT_LIM), .FRAME_LIM(FRAME_LIM), .HOLD_LIM(HOLD_LIM)) u_frame (
    .clk(clk), .rst_n(rst_n), .active(en & rx_mode), .clk_fall(clk_fall), .dat_s(dat_s),
    .par_odd(par_odd), .stop_val(stop_val), .done_ok(ok), .err_par(e_par),
    .err_stop(e_stop), .err_time(e_time), .byte_o(frame_byte), .busy(busy),
    .hold(ps2_clk_oe));

  assign e_any = e_par | e_stop | e_time;

  logic [7:0] data_q, data_d;
  logic       rdy_q, rdy_d, tmo_q, tmo_d, pe_q, pe_d, fe_q, fe_d, irq_q, irq_d;

  // Set terms come after the read clears, so a coincident event wins.
  always_comb begin
    data_d = data_q;
    rdy_d  = rdy_q;
    tmo_d  = tmo_q;
    pe_d   = pe_q;
    fe_d   = fe_q;
    if (!en) begin
      rdy_d = 1'b0;
      tmo_d = 1'b0;
      pe_d  = 1'b0;
      fe_d  = 1'b0;
    end else begin
      if (rd_data) rdy_d = 1'b0;
      if (rd_status) begin
        tmo_d = 1'b0;
        pe_d  = 1'b0;
        fe_d  = 1'b0;
      end
      if (ok) begin
        rdy_d  = 1'b1;
        data_d = frame_byte;
      end
      if (e_any)  tmo_d = 1'b1;
      if (e_par)  pe_d  = 1'b1;
      if (e_stop) fe_d  = 1'b1;
    end
    irq_d = (rdy_d & ~rdy_q) | (tmo_d & ~tmo_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
      tmo_q  <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      rdy_q  <= rdy_d;
      tmo_q  <= tmo_d;
      pe_q   <= pe_d;
      fe_q   <= fe_d;
      irq_q  <= irq_d;
    end
  end

  assign rx_data = data_q;
  assign rdy     = rdy_q;
  assign tmo     = tmo_q;
  assign pe      = pe_q;
  assign fe      = fe_q;
  assign irq     = irq_q;

endmodule

// File: rtl/ps2_rx_channel_chk.sv
module ps2_rx_channel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       rx_mode,
  input logic       rd_data,
  input logic       rd_status,
  input logic       ps2_clk_oe,
  input logic [7:0] rx_data,
  input logic       rdy,
  input logic       pe,
  input logic       fe,
  input logic       tmo,
  input logic       busy,
  input logic       irq
);

  a_r7_hold_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ps2_clk_oe |-> !busy);

  a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!rdy && !tmo && !pe && !fe && !ps2_clk_oe && !busy));

  a_r10_mode_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_mode |=> !busy);

  a_r8_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($rose(rdy) || $rose(tmo)));

  a_r1_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r3_pe_with_tmo: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pe) |-> tmo);

  a_r4_fe_with_tmo: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fe) |-> tmo);

  a_r2_rdy_held: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rdy && !rd_data) |=> rdy);

  a_r8_tmo_held: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tmo && !rd_status) |=> tmo);

endmodule

bind ps2_rx_channel ps2_rx_channel_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .rx_mode(rx_mode), .rd_data(rd_data),
  .rd_status(rd_status), .ps2_clk_oe(ps2_clk_oe), .rx_data(rx_data), .rdy(rdy),
  .pe(pe), .fe(fe), .tmo(tmo), .busy(busy), .irq(irq));

// File: tb/ps2_rx_channel_tb_top.sv
module ps2_rx_channel_tb_top;

  localparam int CPU       = 4;
  localparam int BIT_LIM   = CPU * 300;
  localparam int FRAME_LIM = CPU * 2000;
  localparam int HOLD_LIM  = CPU * 300;
  localparam int HALF      = 10;

  logic clk, rst_n, en, rx_mode, par_odd, stop_val, rd_data, rd_status;
  logic dev_clk, dev_dat;
  logic ps2_clk_i, ps2_clk_oe, rdy, pe, fe, tmo, busy, irq;
  logic [7:0] rx_data;

  assign ps2_clk_i = dev_clk & ~ps2_clk_oe;

  ps2_rx_channel #(.CLK_PER_US(CPU), .BIT_US(300), .FRAME_US(2000), .HOLD_US(300)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .rx_mode(rx_mode), .par_odd(par_odd),
    .stop_val(stop_val), .rd_data(rd_data), .rd_status(rd_status),
    .ps2_clk_i(ps2_clk_i), .ps2_dat_i(dev_dat), .ps2_clk_oe(ps2_clk_oe),
    .rx_data(rx_data), .rdy(rdy), .pe(pe), .fe(fe), .tmo(tmo), .busy(busy), .irq(irq));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int nchk = 0, nfail = 0;
  int irq_cnt = 0, oe_cnt = 0;
  logic busy_seen = 1'b0;

  always @(posedge clk) begin
    if (irq)        irq_cnt <= irq_cnt + 1;
    if (ps2_clk_oe) oe_cnt  <= oe_cnt + 1;
    if (busy)       busy_seen <= 1'b1;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input string what, input int act,
                         input int lo, input int hi);
    nchk++;
    if (act < lo || act > hi) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [10:0] mk_frame(input logic [7:0] b, input logic odd,
                                           input logic stp, input logic pbad,
                                           input logic sbad);
    logic p;
    p = odd ? ~(^b) : (^b);
    return {stp ^ sbad, p ^ pbad, b, 1'b0};
  endfunction

  task automatic send(input logic [10:0] f, input int nbits, input int half);
    for (int i = 0; i < nbits; i++) begin
      dev_dat = f[i];
      idle(half);
      dev_clk = 1'b0;
      idle(half);
      dev_clk = 1'b1;
    end
    dev_dat = 1'b1;
  endtask

  task automatic pulse_rd_data();
    @(negedge clk) rd_data = 1'b1;
    @(negedge clk) rd_data = 1'b0;
  endtask

  task automatic pulse_rd_status();
    @(negedge clk) rd_status = 1'b1;
    @(negedge clk) rd_status = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int i0, o0, w;
    logic [7:0] b, d0;
    logic odd, stp;
    int kind;

    rst_n = 1'b0; en = 1'b0; rx_mode = 1'b0; par_odd = 1'b1; stop_val = 1'b1;
    rd_data = 1'b0; rd_status = 1'b0; dev_clk = 1'b1; dev_dat = 1'b1;
    w = $urandom(32'h5eed_1234);
    idle(5);
    rst_n = 1'b1;
    idle(3);

    // R9: reset state
    chk("R9", "reset outputs", {rdy, tmo, pe, fe, busy, ps2_clk_oe, irq}, 0);
    chk("R9", "reset rx_data", rx_data, 0);

    en = 1'b1; rx_mode = 1'b1;
    idle(3);

    // R1 / R9: directed good frame
    busy_seen = 1'b0;
    i0 = irq_cnt;
    send(mk_frame(8'hA5, 1'b1, 1'b1, 1'b0, 1'b0), 11, HALF);
    idle(4);
    chk("R1", "rx_data", rx_data, 8'hA5);
    chk("R1", "rdy", rdy, 1);
    chk("R1", "irq pulses", irq_cnt - i0, 1);
    chk("R9", "busy seen in frame", busy_seen, 1);
    chk("R9", "busy after frame", busy, 0);

    // R2: overwrite while ready, no new irq
    i0 = irq_cnt;
    send(mk_frame(8'h3E, 1'b1, 1'b1, 1'b0, 1'b0), 11, HALF);
    idle(4);
    chk("R2", "overwrite data", rx_data, 8'h3E);
    chk("R2", "no second irq", irq_cnt - i0, 0);
    chk("R2", "rdy still set", rdy, 1);
    pulse_rd_data();
    idle(1);
    chk("R2", "rdy cleared by read", rdy, 0);

    // Random frames: good, parity error, stop error
    for (int n = 0; n < 24; n++) begin
      b = 8'($urandom); odd = 1'($urandom); stp = 1'($urandom); kind = int'($urandom % 3);
      @(negedge clk); par_odd = odd; stop_val = stp;
      idle(2);
      i0 = irq_cnt; o0 = oe_cnt; d0 = rx_data;
      send(mk_frame(b, odd, stp, kind == 1, kind == 2), 11, HALF);
      idle(4);
      if (kind == 0) begin
        chk("R1", "random byte", rx_data, b);
        chk("R1", "random rdy", rdy, 1);
        chk("R1", "random irq", irq_cnt - i0, 1);
        chk("R3", "no pe on good", pe, 0);
        pulse_rd_data();
        idle(1);
        chk("R2", "random read clears", rdy, 0);
      end else begin
        chk(kind == 1 ? "R3" : "R4", "pe", pe, kind == 1);
        chk(kind == 1 ? "R3" : "R4", "fe", fe, kind == 2);
        chk(kind == 1 ? "R3" : "R4", "tmo", tmo, 1);
        chk(kind == 1 ? "R3" : "R4", "rdy untouched", rdy, 0);
        chk(kind == 1 ? "R3" : "R4", "data untouched", rx_data, d0);
        chk("R8", "irq on tmo rise", irq_cnt - i0, 1);
        idle(HOLD_LIM + 10);
        chk_rng("R7", "hold-off length", oe_cnt - o0, HOLD_LIM, HOLD_LIM + 1);
        chk("R7", "back to idle", busy, 0);
        pulse_rd_status();
        idle(1);
        chk("R8", "status read clears", {tmo, pe, fe}, 0);
      end
    end
    @(negedge clk); par_odd = 1'b1; stop_val = 1'b1;

    // R5 + R8: bit gap timeout while status read is held high
    i0 = irq_cnt; o0 = oe_cnt;
    @(negedge clk) rd_status = 1'b1;
    send(mk_frame(8'h3C, 1'b1, 1'b1, 1'b0, 1'b0), 4, HALF);
    w = 0;
    while (!irq) begin
      @(negedge clk);
      w++;
    end
    rd_status = 1'b0;
    idle(2);
    chk_rng("R5", "cycles to bit timeout", w, BIT_LIM - 20, BIT_LIM + 10);
    chk("R8", "tmo set despite read", tmo, 1);
    chk("R5", "no pe/fe", {pe, fe}, 0);
    chk("R5", "frame dropped", busy, 0);
    idle(HOLD_LIM + 10);
    chk_rng("R7", "hold-off after gap", oe_cnt - o0, HOLD_LIM, HOLD_LIM + 1);
    pulse_rd_status();
    idle(1);
    chk("R8", "tmo cleared", tmo, 0);

    // R6: slow but in-spec bit gaps, whole frame too long
    i0 = irq_cnt;
    send(mk_frame(8'hFF, 1'b1, 1'b1, 1'b0, 1'b0), 10, 450);
    chk("R6", "tmo at frame limit", tmo, 1);
    chk("R6", "not busy", busy, 0);
    chk("R7", "clock held low", ps2_clk_oe, 1);
    chk("R6", "no pe/fe", {pe, fe}, 0);
    idle(HOLD_LIM);
    chk("R8", "one irq", irq_cnt - i0, 1);
    pulse_rd_status();

    // R11: falls with data high in idle
    idle(5);
    i0 = irq_cnt; busy_seen = 1'b0;
    for (int k = 0; k < 3; k++) begin
      dev_dat = 1'b1;
      idle(HALF); dev_clk = 1'b0; idle(HALF); dev_clk = 1'b1;
    end
    idle(5);
    chk("R11", "no start taken", busy_seen, 0);
    chk("R11", "no flags", {rdy, tmo, irq_cnt != i0}, 0);

    // R10: rx_mode abort keeps flags, en clears them
    send(mk_frame(8'h5A, 1'b1, 1'b1, 1'b0, 1'b0), 11, HALF);
    idle(4);
    send(mk_frame(8'h00, 1'b1, 1'b1, 1'b0, 1'b0), 3, HALF);
    @(negedge clk) rx_mode = 1'b0;
    idle(3);
    chk("R10", "mode off drops frame", busy, 0);
    chk("R10", "mode off keeps rdy", rdy, 1);
    chk("R10", "mode off keeps data", rx_data, 8'h5A);
    rx_mode = 1'b1;
    idle(HOLD_LIM + 10);
    @(negedge clk) en = 1'b0;
    idle(2);
    chk("R10", "disable clears rdy", rdy, 0);
    busy_seen = 1'b0;
    send(mk_frame(8'h77, 1'b1, 1'b1, 1'b0, 1'b0), 11, HALF);
    idle(4);
    chk("R10", "no frame while off", {busy_seen, rdy}, 0);
    @(negedge clk) en = 1'b1;
    idle(3);

    // R2: data read coinciding with a completed byte
    @(negedge clk) rd_data = 1'b1;
    fork
      send(mk_frame(8'h81, 1'b1, 1'b1, 1'b0, 1'b0), 11, HALF);
      begin
        while (!irq) @(negedge clk);
        rd_data = 1'b0;
      end
    join
    idle(2);
    chk("R2", "rdy set despite read", rdy, 1);
    chk("R2", "new byte", rx_data, 8'h81);
    pulse_rd_data();
    idle(1);
    chk("R2", "plain read clears", rdy, 0);

    summary();
    $finish;
  end

endmodule